// File: doc/BRIEF.md
# Banked Word Memory with Access-Gated Periphery

A synchronous, word-addressed memory made of equal banks. Each bank holds a number of rows, and each row holds several 32-bit words. The word address is split into a bank field, a row field and a column field. A shared decoder drives one row line, and only the addressed bank acts on it. A column selector picks one word from the sensed row, and a bank selector routes that word to a registered read port. Writes take effect on the rising clock edge at which they are requested.

Every peripheral stage has an enable derived from the access type and the address fields:

- bank enables,
- the row decode,
- the per-bank sense stages.

With no access requested, every enable is low and the stored contents do not change. The enables are brought out as vectors. A cycle counter of enabled accesses is also brought out, so the gating can be observed at the ports.

The full-size configuration has 16 banks, 256 rows and 8 columns, with a 15-bit address. The default row count is reduced to 16 rows (11-bit address) to keep the elaborated storage small. All field widths are parameters.

Top module: `bsram_top`

## Requirements
- R1: The address is read as {bank, row, column}. The bank field is the top BANK_BITS bits, the column field is the low COL_BITS bits, and the row field lies between them. With defaults, bank = addr[10:7], row = addr[6:3], column = addr[2:0].
- R2: A read request (rd_req=1, wr_req=0) sampled at a rising edge loads rdata at that edge with the word stored at the address.
- R3: A write request sampled at a rising edge stores wdata at the address. The stored word is returned by a read in the next cycle, and every other word keeps its value.
- R4: When rd_req and wr_req are both high, only the write takes place, and rdata keeps its previous value.
- R5: On any edge without a read, rdata keeps its previous value.
- R6: During any access, exactly one bit of bank_en is high: bit number = bank field.
- R7: During any access, exactly one bit of row_en is high: bit number = row field.
- R8: sense_en equals bank_en during a read and is all zero during a write or an idle cycle.
- R9: With neither request high, bank_en, row_en and sense_en are all zero, and no stored word changes.
- R10: act_count increases by one at each rising edge where an access was requested. It wraps at 2^CNT_W.
- R11: While rst_n is low, rdata and act_count are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request |
| wr_req | input | 1 | Write request (wins over read) |
| addr | input | ADDR_W (11) | Word address {bank,row,column} |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| bank_en | output | NB (16) | One-hot bank enables |
| row_en | output | NR (16) | One-hot row-line enables |
| sense_en | output | NB (16) | Per-bank sense-stage enables |
| act_count | output | CNT_W (16) | Count of access cycles |

## Verification
Faults in the address split or in the write path show up as wrong read data. Such a fault corrupts or misplaces a word, and it becomes visible on the first read of either the target or a neighbouring word, one cycle after that read. Faults in the gating are visible in the same cycle: an enable vector that is not one-hot, or that is nonzero while the block is idle, appears directly at the enable ports. Faults in the read register appear as rdata changing on a write, on a combined request or on an idle edge. Faults in the counter show as a step other than one per access.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;

   function automatic acc_kind_e classify(input logic rd, input logic wr);
      if (wr)      return ACC_WRITE;
      else if (rd) return ACC_READ;
      else         return ACC_IDLE;
   endfunction
endpackage

// File: rtl/bsram_decode.sv
module bsram_decode
   import bsram_pkg::*;
#(
   parameter int BANK_BITS = 4,
   parameter int ROW_BITS  = 4,
   parameter int COL_BITS  = 3,
   localparam int ADDR_W   = BANK_BITS + ROW_BITS + COL_BITS,
   localparam int NB       = 1 << BANK_BITS,
   localparam int NR       = 1 << ROW_BITS
) (
   input  logic                 rd_req,
   input  logic                 wr_req,
   input  logic [ADDR_W-1:0]    addr,
   output logic [NB-1:0]        bank_en,
   output logic [NR-1:0]        row_en,
   output logic [NB-1:0]        sense_en,
   output logic [ROW_BITS-1:0]  row_idx,
   output logic [COL_BITS-1:0]  col_idx,
   output logic [BANK_BITS-1:0] bank_idx,
   output logic                 do_read,
   output logic                 do_write
);
   acc_kind_e kind;
   logic      active;

   assign kind     = classify(rd_req, wr_req);
   assign active   = (kind != ACC_IDLE);
   assign do_read  = (kind == ACC_READ);
   assign do_write = (kind == ACC_WRITE);

   assign bank_idx = addr[ADDR_W-1 -: BANK_BITS];
   assign row_idx  = addr[COL_BITS +: ROW_BITS];
   assign col_idx  = addr[COL_BITS-1:0];

   for (genvar b = 0; b < NB; b++) begin : g_bank_dec
      assign bank_en[b]  = active  && (bank_idx == BANK_BITS'(b));
      assign sense_en[b] = do_read && (bank_idx == BANK_BITS'(b));
   end

   if (ROW_BITS >= 2) begin : g_row_predec
      localparam int LO_B = ROW_BITS / 2;
      localparam int HI_B = ROW_BITS - LO_B;
      logic [(1<<LO_B)-1:0] pre_lo;
      logic [(1<<HI_B)-1:0] pre_hi;
      for (genvar i = 0; i < (1<<LO_B); i++) begin : g_lo
         assign pre_lo[i] = active && (row_idx[LO_B-1:0] == LO_B'(i));
      end
      for (genvar j = 0; j < (1<<HI_B); j++) begin : g_hi
         assign pre_hi[j] = (row_idx[ROW_BITS-1:LO_B] == HI_B'(j));
      end
      for (genvar r = 0; r < NR; r++) begin : g_row
         assign row_en[r] = pre_hi[r >> LO_B] & pre_lo[r & ((1<<LO_B)-1)];
      end
   end else begin : g_row_flat
      for (genvar r = 0; r < NR; r++) begin : g_row
         assign row_en[r] = active && (row_idx == ROW_BITS'(r));
      end
   end
endmodule

// File: rtl/bsram_bank.sv
module bsram_bank #(
   parameter int DATA_W   = 32,
   parameter int ROW_BITS = 4,
   parameter int COL_BITS = 3,
   localparam int NR      = 1 << ROW_BITS,
   localparam int NC      = 1 << COL_BITS,
   localparam int DEPTH   = NR * NC
) (
   input  logic                clk,
   input  logic                bank_on,
   input  logic                sense_on,
   input  logic                we,
   input  logic [NR-1:0]       row_line,
   input  logic [ROW_BITS-1:0] row_idx,
   input  logic [COL_BITS-1:0] col_idx,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   word_out
);
   logic [DATA_W-1:0] cells [DEPTH];
   logic [DATA_W-1:0] row_words [NC];

   always_ff @(posedge clk) begin
      if (bank_on && we)
         cells[{row_idx, col_idx}] <= wdata;
   end

   always_comb begin
      for (int c = 0; c < NC; c++) begin
         row_words[c] = '0;
         for (int r = 0; r < NR; r++) begin
            if (sense_on && row_line[r])
               row_words[c] = row_words[c] | cells[r*NC + c];
         end
      end
   end

   assign word_out = sense_on ? row_words[col_idx] : '0;
endmodule

// File: rtl/bsram_outsel.sv
module bsram_outsel #(
   parameter int DATA_W     = 32,
   parameter int BANK_BITS  = 4,
   parameter bit ONEHOT_MUX = 1'b1,
   localparam int NB        = 1 << BANK_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 capture,
   input  logic [BANK_BITS-1:0] bank_idx,
   input  logic [NB*DATA_W-1:0] bank_words,
   output logic [DATA_W-1:0]    rdata
);
   logic [DATA_W-1:0] picked;

   if (ONEHOT_MUX) begin : g_andor
      always_comb begin
         picked = '0;
         for (int b = 0; b < NB; b++)
            picked = picked | bank_words[b*DATA_W +: DATA_W];
      end
   end else begin : g_index
      assign picked = bank_words[bank_idx*DATA_W +: DATA_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       rdata <= '0;
      else if (capture) rdata <= picked;
   end
endmodule

// File: rtl/bsram_top.sv
module bsram_top #(
   parameter int DATA_W     = 32,
   parameter int BANK_BITS  = 4,
   parameter int ROW_BITS   = 4,
   parameter int COL_BITS   = 3,
   parameter int CNT_W      = 16,
   parameter bit ONEHOT_MUX = 1'b1,
   localparam int ADDR_W    = BANK_BITS + ROW_BITS + COL_BITS,
   localparam int NB        = 1 << BANK_BITS,
   localparam int NR        = 1 << ROW_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [NB-1:0]     bank_en,
   output logic [NR-1:0]     row_en,
   output logic [NB-1:0]     sense_en,
   output logic [CNT_W-1:0]  act_count
);
   initial begin
      if (DATA_W < 1)    $error("DATA_W must be positive");
      if (BANK_BITS < 1) $error("BANK_BITS must be positive");
      if (ROW_BITS < 1)  $error("ROW_BITS must be positive");
      if (COL_BITS < 1)  $error("COL_BITS must be positive");
      if (CNT_W < 1)     $error("CNT_W must be positive");
   end

   logic [ROW_BITS-1:0]  row_idx;
   logic [COL_BITS-1:0]  col_idx;
   logic [BANK_BITS-1:0] bank_idx;
   logic                 do_read;
   logic                 do_write;
   logic [NB*DATA_W-1:0] bank_words;

   bsram_decode #(
      .BANK_BITS(BANK_BITS), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)
   ) dec_i (
      .rd_req(rd_req), .wr_req(wr_req), .addr(addr),
      .bank_en(bank_en), .row_en(row_en), .sense_en(sense_en),
      .row_idx(row_idx), .col_idx(col_idx), .bank_idx(bank_idx),
      .do_read(do_read), .do_write(do_write)
   );

   for (genvar b = 0; b < NB; b++) begin : g_banks
      bsram_bank #(
         .DATA_W(DATA_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)
      ) bank_i (
         .clk(clk),
         .bank_on(bank_en[b]),
         .sense_on(sense_en[b]),
         .we(do_write),
         .row_line(row_en),
         .row_idx(row_idx),
         .col_idx(col_idx),
         .wdata(wdata),
         .word_out(bank_words[b*DATA_W +: DATA_W])
      );
   end

   bsram_outsel #(
      .DATA_W(DATA_W), .BANK_BITS(BANK_BITS), .ONEHOT_MUX(ONEHOT_MUX)
   ) out_i (
      .clk(clk), .rst_n(rst_n), .capture(do_read),
      .bank_idx(bank_idx), .bank_words(bank_words), .rdata(rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                  act_count <= '0;
      else if (do_read || do_write) act_count <= act_count + 1'b1;
   end
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
   parameter int DATA_W    = 32,
   parameter int BANK_BITS = 4,
   parameter int ROW_BITS  = 4,
   parameter int ADDR_W    = 11,
   parameter int CNT_W     = 16,
   parameter int NB        = 16,
   parameter int NR        = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_req,
   input logic              wr_req,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] rdata,
   input logic [NB-1:0]     bank_en,
   input logic [NR-1:0]     row_en,
   input logic [NB-1:0]     sense_en,
   input logic [CNT_W-1:0]  act_count
);
   localparam int COL_B = ADDR_W - BANK_BITS - ROW_BITS;

   assert_bank_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req || wr_req) |-> ($countones(bank_en) == 1 &&
                              bank_en[addr[ADDR_W-1:ADDR_W-BANK_BITS]]));

   assert_row_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req || wr_req) |-> ($countones(row_en) == 1 &&
                              row_en[addr[COL_B +: ROW_BITS]]));

   assert_sense_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !wr_req) |-> (sense_en == bank_en));

   assert_sense_off_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> (sense_en == '0));

   assert_idle_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_req && !wr_req) |-> (bank_en == '0 && row_en == '0 && sense_en == '0));

   assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_req || wr_req) |=> $stable(rdata));

   assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req || wr_req) |=> (act_count == $past(act_count) + 1'b1));

   assert_count_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_req && !wr_req) |=> $stable(act_count));
endmodule

bind bsram_top bsram_chk #(
   .DATA_W(DATA_W), .BANK_BITS(BANK_BITS), .ROW_BITS(ROW_BITS),
   .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NB(NB), .NR(NR)
) chk_i (
   .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .addr(addr),
   .rdata(rdata), .bank_en(bank_en), .row_en(row_en), .sense_en(sense_en),
   .act_count(act_count)
);

// File: tb/bsram_top_tb_top.sv
module bsram_top_tb_top;
   localparam int DW = 32;
   localparam int AW = 11;
   localparam int NB = 16;
   localparam int NR = 16;
   localparam int CW = 16;

   typedef struct packed {
      logic          rd;
      logic          wr;
      logic [AW-1:0] ad;
      logic [DW-1:0] wd;
   } vec_t;

   // address = {bank[3:0], row[3:0], col[2:0]}  (R1)
   localparam vec_t VEC [16] = '{
      '{1'b0, 1'b1, {4'd0,  4'd0,  3'd0}, 32'h1111_0000},
      '{1'b0, 1'b1, {4'd15, 4'd15, 3'd7}, 32'hFFFF_0007},
      '{1'b0, 1'b1, {4'd5,  4'd3,  3'd2}, 32'h0503_0002},
      '{1'b0, 1'b1, {4'd5,  4'd3,  3'd3}, 32'h0503_0003},
      '{1'b0, 1'b1, {4'd5,  4'd3,  3'd4}, 32'h0503_0004},
      '{1'b0, 1'b1, {4'd10, 4'd3,  3'd3}, 32'h0A03_0003},
      '{1'b1, 1'b0, {4'd5,  4'd3,  3'd3}, 32'hDEAD_BEEF},
      '{1'b1, 1'b0, {4'd0,  4'd0,  3'd0}, 32'h0},
      '{1'b0, 1'b0, {4'd15, 4'd15, 3'd7}, 32'hBAD0_0001},
      '{1'b1, 1'b0, {4'd15, 4'd15, 3'd7}, 32'h0},
      '{1'b1, 1'b1, {4'd5,  4'd3,  3'd3}, 32'h5555_AAAA},
      '{1'b1, 1'b0, {4'd5,  4'd3,  3'd2}, 32'h0},
      '{1'b1, 1'b0, {4'd5,  4'd3,  3'd3}, 32'h0},
      '{1'b1, 1'b0, {4'd5,  4'd3,  3'd4}, 32'h0},
      '{1'b1, 1'b0, {4'd10, 4'd3,  3'd3}, 32'h0},
      '{1'b0, 1'b1, {4'd10, 4'd3,  3'd3}, 32'h7777_7777}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_req = 1'b0;
   logic          wr_req = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic [NB-1:0] bank_en;
   logic [NR-1:0] row_en;
   logic [NB-1:0] sense_en;
   logic [CW-1:0] act_count;

   int checks = 0;
   int fails  = 0;
   logic [DW-1:0] ref_mem [1 << AW];
   logic [DW-1:0] exp_rd;
   logic [CW-1:0] exp_cnt;
   bit            done = 1'b0;

   always #5 clk = ~clk;

   bsram_top dut_i (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
      .addr(addr), .wdata(wdata), .rdata(rdata), .bank_en(bank_en),
      .row_en(row_en), .sense_en(sense_en), .act_count(act_count)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cycle(input logic rd, input logic wr, input logic [AW-1:0] ad,
                        input logic [DW-1:0] wd);
      logic [NB-1:0] eb;
      logic [NR-1:0] er;
      @(negedge clk);
      rd_req = rd; wr_req = wr; addr = ad; wdata = wd;
      #1;
      eb = (rd || wr) ? (NB'(1) << ad[10:7]) : '0;
      er = (rd || wr) ? (NR'(1) << ad[6:3])  : '0;
      check("R6 bank_en", 64'(bank_en), 64'(eb));
      check("R7 row_en",  64'(row_en),  64'(er));
      check("R8 sense_en", 64'(sense_en), 64'((rd && !wr) ? eb : '0));
      if (!rd && !wr) check("R9 idle enables", 64'(bank_en | sense_en), 64'(0));
      if (wr) ref_mem[ad] = wd;
      else if (rd) exp_rd = ref_mem[ad];
      if (rd || wr) exp_cnt = exp_cnt + 1'b1;
      @(posedge clk);
      #1;
      check((rd && !wr) ? "R2 read data" : "R4/R5 rdata hold", 64'(rdata), 64'(exp_rd));
      check("R10 act_count", 64'(act_count), 64'(exp_cnt));
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      exp_rd = '0; exp_cnt = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R11 reset rdata", 64'(rdata), 64'(0));
      check("R11 reset act_count", 64'(act_count), 64'(0));
      @(negedge clk) rst_n = 1'b1;

      // R1 R2 R3 R4 R5 R9: table walk
      for (int i = 0; i < 16; i++)
         cycle(VEC[i].rd, VEC[i].wr, VEC[i].ad, VEC[i].wd);

      // R3: overwrite then read next cycle, neighbours intact
      cycle(1'b1, 1'b0, {4'd10, 4'd3, 3'd3}, '0);
      cycle(1'b0, 1'b1, {4'd5, 4'd3, 3'd2}, 32'hCAFE_0001);
      cycle(1'b1, 1'b0, {4'd5, 4'd3, 3'd2}, '0);
      cycle(1'b1, 1'b0, {4'd5, 4'd3, 3'd3}, '0);

      // R9: idle cycles with changing data do not alter contents
      for (int k = 0; k < 4; k++)
         cycle(1'b0, 1'b0, {4'd5, 4'd3, 3'd2}, 32'h0BAD_0000 + k);
      cycle(1'b1, 1'b0, {4'd5, 4'd3, 3'd2}, '0);
      cycle(1'b1, 1'b0, {4'd15, 4'd15, 3'd7}, '0);

      // R1: same row/col in every bank holds a distinct word
      for (int b = 0; b < 16; b++)
         cycle(1'b0, 1'b1, {4'(b), 4'd9, 3'd6}, 32'hB000_0000 + b);
      for (int b = 15; b >= 0; b--)
         cycle(1'b1, 1'b0, {4'(b), 4'd9, 3'd6}, '0);

      // R11: reset mid-run clears output and counter
      @(negedge clk);
      rd_req = 1'b0; wr_req = 1'b0; rst_n = 1'b0;
      @(posedge clk); #1;
      check("R11 reset rdata again", 64'(rdata), 64'(0));
      check("R11 reset act_count again", 64'(act_count), 64'(0));
      @(negedge clk) rst_n = 1'b1;
      exp_rd = '0; exp_cnt = '0;
      cycle(1'b1, 1'b0, {4'd0, 4'd0, 3'd0}, '0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule